// File: doc/BRIEF.md
# Slave Serial Readout Port with Daisy-Chain

This block is the slave readout port of a converter. An external host supplies the serial clock and a chip-select. The port then shifts the latest conversion word out on a single data line, most significant bit first. The host can read a finished word once the converter reports that it is no longer busy. It can also read the previous word while the next conversion is still running. In the read-after-conversion case, the data line carries on past the local word with bits taken from an upstream device's data output. Several ports can therefore share one chain. In the read-during-conversion case, the port raises a one-clock error pulse when the host has not fetched the full word by the end of the conversion.

The host-side pins (`sclk`, `cs_n`, `rd_n`, `sdin`) are asynchronous. They pass through a synchroniser into the system clock domain, and an oversampling edge detector finds the serial clock edges. The conversion word arrives on a valid-only strobe, `res_valid` with `res_data`. It is taken on every cycle in which the strobe is high. There is no ready signal and no back-pressure: a new word simply replaces the held one. `busy` and `ext_sel` are synchronous control levels.

Top module: `ssp_slave_port`

## Requirements
- R1: After reset, `sdout` and `rderror` are both 0.
- R2: While `ext_sel` is 0, the port is idle. `sdout` stays 0, serial clock edges and chip-select falls change nothing, and `rderror` never pulses.
- R3: `sdout` is 0 unless `cs_n` and `rd_n` are both 0. Serial clock edges that occur while `rd_n` is 1 do not advance the word.
- R4: A falling edge of `cs_n` loads the held word, and its most significant bit (bit WIDTH-1) appears on `sdout`. Each falling edge of `sclk` then moves `sdout` to the next lower bit, so bit 0 shows after WIDTH-1 falling edges.
- R5: `sclk` is ignored while `cs_n` is 1. A rise of `cs_n` clears the bit count, so the next fall of `cs_n` restarts the transfer from the most significant bit.
- R6: With `busy` at 0, `sdin` is sampled on each rising edge of `sclk` and enters the least significant position at the next falling edge. The upstream word's most significant bit therefore shows on `sdout` at falling edge WIDTH, immediately after the local bit 0.
- R7: With `busy` at 1, the bits shifted in behind the local word are 0 whatever level `sdin` has.
- R8: If a load happens while `busy` is 1, `rderror` pulses when `busy` falls unless WIDTH falling edges of `sclk` were counted after that load. `rderror` does not pulse when no load happened during `busy`.
- R9: A pulse of `rderror` lasts exactly one clock cycle. It is high in the cycle after the first rising clock edge that samples `busy` low.
- R10: `res_valid` high captures `res_data` into the held word. A capture during a transfer does not disturb the bits being shifted, and the new word appears at the next fall of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sel | input | 1 | 1 selects host-clocked slave operation |
| sclk | input | 1 | Host serial clock, asynchronous |
| cs_n | input | 1 | Chip-select, active low, asynchronous |
| rd_n | input | 1 | Read enable, active low, asynchronous |
| sdin | input | 1 | Serial data from the upstream device |
| busy | input | 1 | Conversion in progress, synchronous |
| res_valid | input | 1 | Strobe: `res_data` holds a new word |
| res_data | input | WIDTH | Conversion word |
| sdout | output | 1 | Serial data out, MSB first |
| rderror | output | 1 | One-clock pulse on an incomplete read during conversion |

## Verification
The bench builds the port with WIDTH=4 and a two-stage synchroniser. The short word lets it sweep every local word against every upstream word through a full eight-bit chained read. It also makes every partial read length, from no bits up to the full word, reachable inside a single conversion window, so each case of the error pulse is covered. The two-stage setting keeps the synchroniser latency short, so eight system clocks per serial half-period always cover the latency.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // positions of the host pins on the synchroniser bus
  localparam int PIN_SCLK = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_RD   = 2;
  localparam int PIN_SDIN = 3;
  localparam int NPINS    = 4;
  // reset level of each pin: chip-select and read idle high
  localparam logic [NPINS-1:0] PIN_IDLE = 4'b0110;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe[s] <= RST_VAL;
      else if (s == 0) pipe[s] <= d;
      else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/ssp_edge.sv
module ssp_edge #(
  parameter int N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~prev[i];
    assign fall[i] = ~lvl[i] & prev[i];
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             shift,
  input  logic             capture,
  input  logic             sdin_bit,
  input  logic             zero_fill,
  input  logic             clr_cnt,
  output logic             msb,
  output logic             idle,
  output logic             done
);
  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    cnt;
  logic             cap;

  // chained bit taken on the edge opposite to the shift edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap <= 1'b0;
    else if (capture) cap <= zero_fill ? 1'b0 : sdin_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (load) begin
      shreg <= load_word;
      cnt   <= '0;
    end else if (shift) begin
      shreg <= {shreg[WIDTH-2:0], cap};
      if (cnt != CW'(WIDTH)) cnt <= cnt + 1'b1;
    end else if (clr_cnt) begin
      cnt <= '0;
    end
  end

  assign msb  = shreg[WIDTH-1];
  assign idle = (cnt == '0);
  assign done = (cnt == CW'(WIDTH));

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WIDTH));

  assert_hold_without_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(shift)) |-> $stable(shreg));
endmodule

// File: rtl/ssp_rderr.sv
module ssp_rderr (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic busy,
  input  logic start,
  input  logic done,
  output logic rderror
);
  logic busy_q;
  logic pending;
  logic busy_fall;

  assign busy_fall = busy_q & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pending <= 1'b0;
      rderror <= 1'b0;
    end else begin
      busy_q  <= busy;
      rderror <= en & busy_fall & pending;
      if (busy_fall || done) pending <= 1'b0;
      else if (start && busy) pending <= 1'b1;
    end
  end

  assert_err_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rderror |=> !rderror);

  assert_err_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rderror |-> (!$past(busy) && $past(busy, 2)));

  assert_err_needs_slave_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rderror |-> $past(en));
endmodule

// File: rtl/ssp_slave_port.sv
module ssp_slave_port
  import ssp_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             sdin,
  input  logic             busy,
  input  logic             res_valid,
  input  logic [WIDTH-1:0] res_data,
  output logic             sdout,
  output logic             rderror
);
  logic [NPINS-1:0] pins_s;
  logic [1:0]       rise, fall;
  logic [WIDTH-1:0] held;
  logic             active, load, msb, idle, done;

  ssp_sync #(.N(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdin, rd_n, cs_n, sclk}),
    .q(pins_s)
  );

  // bit 0: serial clock, bit 1: chip-select
  ssp_edge #(.N(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({pins_s[PIN_CS], pins_s[PIN_SCLK]}),
    .rise(rise), .fall(fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= '0;
    else if (res_valid) held <= res_data;
  end

  assign active = ext_sel & ~pins_s[PIN_CS] & ~pins_s[PIN_RD];
  assign load   = ext_sel & fall[1] & idle;

  ssp_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_word(held),
    .shift(active & fall[0]),
    .capture(active & rise[0]),
    .sdin_bit(pins_s[PIN_SDIN]),
    .zero_fill(busy),
    .clr_cnt(rise[1]),
    .msb(msb), .idle(idle), .done(done)
  );

  ssp_rderr u_err (
    .clk(clk), .rst_n(rst_n),
    .en(ext_sel), .busy(busy),
    .start(load), .done(done),
    .rderror(rderror)
  );

  assign sdout = active & msb;

  assert_sdout_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sdout |-> (!pins_s[PIN_CS] && !pins_s[PIN_RD] && ext_sel));
endmodule

// File: tb/ssp_slave_port_bench.sv
module ssp_slave_port_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sel = 1'b1, sclk = 1'b0, cs_n = 1'b1, rd_n = 1'b1, sdin = 1'b0;
  logic busy = 1'b0, res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic sdout, rderror;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  ssp_slave_port #(.WIDTH(W), .SYNC_STAGES(2)) u_ssp_slave_port (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .sclk(sclk), .cs_n(cs_n),
    .rd_n(rd_n), .sdin(sdin), .busy(busy), .res_valid(res_valid),
    .res_data(res_data), .sdout(sdout), .rderror(rderror)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk); res_data = d; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic pulse(input logic b);
    sdin = b; wait_n(4);
    sclk = 1'b1; wait_n(8);
    sclk = 1'b0; wait_n(8);
  endtask

  task automatic set_cs(input logic v);
    cs_n = v; wait_n(8);
  endtask

  // drop busy and watch the error line for a few cycles
  task automatic end_conv(input int exp, input string tag);
    int cnt;
    int first;
    @(negedge clk); busy = 1'b0;
    @(negedge clk); first = rderror; cnt = first;
    for (int i = 0; i < 5; i++) begin @(negedge clk); cnt += rderror; end
    check({tag, " R9 first-cycle"}, first, exp);
    check({tag, " R8 pulse count"}, cnt, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    check("R1 sdout reset", sdout, 0);
    check("R1 rderror reset", rderror, 0);
    rst_n = 1'b1; wait_n(3);
    check("R1 sdout after release", sdout, 0);

    // R4 / R6: every local word against every upstream word
    rd_n = 1'b0;
    for (int d = 0; d < 16; d++) begin
      for (int u = 0; u < 16; u++) begin
        logic [7:0] stream;
        stream = {u[3:0], 4'b0000};
        push(d[3:0]);
        set_cs(1'b0);
        check("R4 msb on cs fall", sdout, d[3]);
        for (int k = 1; k <= 8; k++) begin
          int expv;
          pulse(stream[8-k]);
          expv = (k < 4) ? d[3-k] : ((k < 8) ? u[7-k] : 0);
          if (k < 4) check("R4 local bit", sdout, expv);
          else       check("R6 chained bit", sdout, expv);
        end
        set_cs(1'b1);
      end
    end
    check("R3 sdout with cs high", sdout, 0);

    // R7: chained bits are zero during conversion; full read gives no error
    for (int d = 0; d < 16; d++) begin
      busy = 1'b1;
      push(d[3:0]);
      set_cs(1'b0);
      for (int k = 1; k <= 8; k++) begin
        pulse(1'b1);
        if (k < 4) check("R7 local bit", sdout, d[3-k]);
        else       check("R7 zero fill", sdout, 0);
      end
      set_cs(1'b1);
      end_conv(0, "R8 full read");
    end

    // R8 / R9: partial reads of every length
    push(4'hA);
    for (int n = 0; n <= 4; n++) begin
      busy = 1'b1; wait_n(2);
      set_cs(1'b0);
      for (int k = 0; k < n; k++) pulse(1'b0);
      set_cs(1'b1);
      end_conv((n < 4) ? 1 : 0, "R8 partial");
    end
    busy = 1'b1; wait_n(4);
    end_conv(0, "R8 no read");

    // R5: clock ignored with cs high; restart clears the count
    push(4'b1001);
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    set_cs(1'b0);
    check("R5 msb after ignored clocks", sdout, 1);
    pulse(1'b0);
    check("R5 bit2", sdout, 0);
    pulse(1'b0);
    set_cs(1'b1);
    set_cs(1'b0);
    check("R5 restart from msb", sdout, 1);
    pulse(1'b0);
    check("R5 restart bit2", sdout, 0);
    set_cs(1'b1);

    // R3: rd high blocks output and shifting
    push(4'b1010);
    rd_n = 1'b1;
    set_cs(1'b0);
    check("R3 sdout rd high", sdout, 0);
    pulse(1'b0); pulse(1'b0);
    rd_n = 1'b0; wait_n(8);
    check("R3 no shift while rd high", sdout, 1);
    pulse(1'b0);
    check("R3 next bit", sdout, 0);
    set_cs(1'b1);

    // R2: slave mode off
    ext_sel = 1'b0;
    push(4'b1000);
    busy = 1'b1; wait_n(2);
    set_cs(1'b0);
    check("R2 sdout idle", sdout, 0);
    pulse(1'b0);
    set_cs(1'b1);
    end_conv(0, "R2 no error");
    ext_sel = 1'b1; wait_n(2);
    set_cs(1'b0);
    check("R2 msb after enable", sdout, 1);
    pulse(1'b0);
    check("R2 next bit", sdout, 0);
    set_cs(1'b1);

    // R10: capture mid-transfer does not disturb
    push(4'b0110);
    set_cs(1'b0);
    pulse(1'b0);
    check("R10 bit2 of first", sdout, 1);
    push(4'b1001);
    pulse(1'b0);
    check("R10 bit1 of first", sdout, 1);
    pulse(1'b0);
    check("R10 bit0 of first", sdout, 0);
    set_cs(1'b1);
    set_cs(1'b0);
    check("R10 new word msb", sdout, 1);
    set_cs(1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule